// File: doc/BRIEF.md
# Masked Input Transition Interrupt Controller

This block watches a word of asynchronous digital inputs and requests an interrupt when chosen inputs change level in a chosen direction. Each input has an enable bit and a direction bit. A rising-edge direction bit makes a low-to-high change count as an event. A falling-edge direction bit makes a high-to-low change count as an event. Events accumulate in a counter. The interrupt is raised once the count reaches a programmable preset, and the counter then returns to zero.

When the interrupt is raised, the inputs that caused it are merged into a retentive changed-bits register. Software clears that register by writing zero to it. If the register still holds bits when the next interrupt latches, a sticky overlap fault is set. The interrupt request stays high until the handler start strobe acknowledges it. The time from the handler start strobe to the handler done strobe is measured in ticks of an external 1 ms pulse. The block keeps the duration of the last run and the longest run seen.

Interrupts are enabled by an arm strobe that is given when the system enters run mode. If the input group is reported absent at that strobe, a sticky configuration fault is set and interrupts stay off until reset.

Top module: `edge_irq_ctrl`

## Requirements
- R1: An input whose bit in the enable register (address 0) is 0 produces no events: its transitions leave the event count and the interrupt request unchanged.
- R2: For an enabled input, direction bit 1 (address 1) counts only low-to-high changes and direction bit 0 counts only high-to-low changes. Each qualifying input in a cycle counts as one event.
- R3: The event count (address 3) holds the qualifying events since the last interrupt. With preset (address 2, 15 bits) 0 or 1, every event raises the interrupt. With preset N>1, the interrupt is raised when the count reaches N, and the count returns to 0.
- R4: A write to the enable register or the preset register clears the event count. Events in the cycle of that write are discarded.
- R5: The changed-bits register (address 4) ORs in the inputs that produced the triggering events. It is cleared only by writing 0 to it. A nonzero write is ignored.
- R6: If the changed-bits register is nonzero when an interrupt latches, the sticky overlap flag (status bit 0) is set. A zero write in the same cycle as the latch is applied first, so no overlap is flagged in that case.
- R7: The interrupt request stays high until a handler start strobe. If a new interrupt latches in the same cycle as the start strobe, the request stays high.
- R8: The last-duration register (address 5) receives the number of 1 ms ticks seen from a start strobe up to and including the cycle of the done strobe. A done strobe with no run in progress is ignored.
- R9: The maximum-duration register (address 6) takes the new last duration whenever that duration exceeds the stored maximum.
- R10: An arm strobe with the group-present input high enables events (status bit 2). With group-present low, it sets the sticky configuration fault (status bit 1) and disarms. While unarmed or faulted, no events count and no interrupt is raised.
- R11: Reset clears every register, counter and flag, disables all inputs and deasserts the interrupt request.
- R12: Register addresses: 0 enable, 1 direction, 2 preset, 3 count, 4 changed, 5 last, 6 max, 7 status. Status bit 3 mirrors the interrupt request. Reads are combinational and zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_word | input | 16 | Monitored asynchronous inputs |
| group_ok | input | 1 | Monitored group is present and valid |
| arm | input | 1 | Run-mode entry strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| hdl_start | input | 1 | Handler start strobe, acknowledges the request |
| hdl_done | input | 1 | Handler done strobe |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of actions can fall in the same cycle and are tested directly. The first pair is a software zero-write to the changed-bits register and a new interrupt latch. The second pair is a handler start strobe and a new interrupt latch. The bench counts the synchronizer stages and places the input change two cycles ahead, so that the write or the strobe lands in exactly the cycle in which the edge is judged. The expected outcome in the first case is changed bits equal to only the new inputs, with the overlap flag still clear. The expected outcome in the second case is a request that stays high, an overlap flag that is set, and changed bits that hold both the old and the new inputs.

// File: rtl/eic_pkg.sv
package eic_pkg;

    typedef enum logic [2:0] {
        REG_ENABLE  = 3'd0,
        REG_DIR     = 3'd1,
        REG_PRESET  = 3'd2,
        REG_COUNT   = 3'd3,
        REG_CHANGED = 3'd4,
        REG_LAST    = 3'd5,
        REG_MAX     = 3'd6,
        REG_STATUS  = 3'd7
    } reg_sel_e;

    localparam int ST_OVERLAP  = 0;
    localparam int ST_CFGFAULT = 1;
    localparam int ST_ARMED    = 2;
    localparam int ST_IRQ      = 3;

endpackage

// File: rtl/eic_edge_sense.sv
module eic_edge_sense #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins,
    input  logic [WIDTH-1:0] enable_bits,
    input  logic [WIDTH-1:0] dir_bits,
    output logic [WIDTH-1:0] hits
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] sync;
        logic [WIDTH-1:0] prev;
    } sense_t;

    sense_t d, q;

    always_comb begin
        d      = q;
        d.meta = pins;
        d.sync = q.meta;
        d.prev = q.sync;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic rise_w, fall_w;
        assign rise_w  = q.sync[i] & ~q.prev[i];
        assign fall_w  = ~q.sync[i] & q.prev[i];
        assign hits[i] = enable_bits[i] & (dir_bits[i] ? rise_w : fall_w);
    end

endmodule

// File: rtl/eic_trigger.sv
module eic_trigger #(
    parameter int WIDTH = 16,
    parameter int PRE_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] hits,
    input  logic             active,
    input  logic             cnt_clr,
    input  logic [PRE_W-1:0] preset,
    input  logic             chg_clr,
    input  logic             ack,
    output logic [PRE_W:0]   count,
    output logic [WIDTH-1:0] changed,
    output logic             overlap,
    output logic             irq
);

    localparam int CNT_W = PRE_W + 1;
    localparam int NUM_W = $clog2(WIDTH + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [WIDTH-1:0] acc;
        logic [WIDTH-1:0] chg;
        logic             ovl;
        logic             req;
    } trig_t;

    trig_t d, q;
    logic [NUM_W-1:0] num_hits;
    logic [CNT_W:0]   sum;
    logic [CNT_W:0]   thr;

    always_comb begin
        num_hits = '0;
        for (int i = 0; i < WIDTH; i++) begin
            num_hits = num_hits + NUM_W'(hits[i]);
        end
    end

    always_comb begin
        if (preset <= PRE_W'(1)) thr = (CNT_W+1)'(1);
        else                     thr = (CNT_W+1)'(preset);
        sum = {1'b0, q.cnt} + (CNT_W+1)'(num_hits);
    end

    always_comb begin
        d = q;
        if (ack)     d.req = 1'b0;
        if (chg_clr) d.chg = '0;
        if (cnt_clr) begin
            d.cnt = '0;
            d.acc = '0;
        end else if (active && (num_hits != '0)) begin
            if (sum >= thr) begin
                d.req = 1'b1;
                d.cnt = '0;
                d.acc = '0;
                if (d.chg != '0) d.ovl = 1'b1;
                d.chg = d.chg | q.acc | hits;
            end else begin
                d.cnt = sum[CNT_W-1:0];
                d.acc = q.acc | hits;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign count   = q.cnt;
    assign changed = q.chg;
    assign overlap = q.ovl;
    assign irq     = q.req;

    // R3
    count_below_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, q.cnt} < thr));

    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.req && !ack) |=> q.req);

    // R6
    overlap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.ovl |=> q.ovl);

    // R5
    changed_retain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chg_clr |=> ((q.chg & $past(q.chg)) == $past(q.chg)));

endmodule

// File: rtl/eic_dur_timer.sv
module eic_dur_timer #(
    parameter int DUR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             done,
    input  logic             tick,
    output logic [DUR_W-1:0] last_dur,
    output logic [DUR_W-1:0] max_dur
);

    typedef struct packed {
        logic             busy;
        logic [DUR_W-1:0] elapsed;
        logic [DUR_W-1:0] last;
        logic [DUR_W-1:0] peak;
    } tmr_t;

    tmr_t d, q;
    logic [DUR_W-1:0] el_next;

    always_comb begin
        el_next = q.elapsed;
        if (tick && (q.elapsed != '1)) el_next = q.elapsed + DUR_W'(1);
    end

    always_comb begin
        d = q;
        if (start) begin
            d.busy    = 1'b1;
            d.elapsed = '0;
        end else if (q.busy) begin
            d.elapsed = el_next;
            if (done) begin
                d.busy = 1'b0;
                d.last = el_next;
                if (el_next > q.peak) d.peak = el_next;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign last_dur = q.last;
    assign max_dur  = q.peak;

    // R9
    max_ge_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.peak >= q.last));

    // R8
    last_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(q.last));

endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
    parameter int IN_W  = 16,
    parameter int PRE_W = 15,
    parameter int DUR_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IN_W-1:0] in_word,
    input  logic            group_ok,
    input  logic            arm,
    input  logic            wr_en,
    input  logic [2:0]      wr_addr,
    input  logic [IN_W-1:0] wr_data,
    input  logic [2:0]      rd_addr,
    output logic [IN_W-1:0] rd_data,
    input  logic            tick_ms,
    input  logic            hdl_start,
    input  logic            hdl_done,
    output logic            irq
);
    import eic_pkg::*;

    localparam int CNT_W = PRE_W + 1;

    typedef struct packed {
        logic [IN_W-1:0]  en_bits;
        logic [IN_W-1:0]  dir_bits;
        logic [PRE_W-1:0] preset;
        logic             armed;
        logic             cfg_fault;
    } cfg_t;

    cfg_t d, q;

    logic [IN_W-1:0]  hits;
    logic [CNT_W-1:0] count;
    logic [IN_W-1:0]  changed;
    logic             overlap;
    logic             irq_w;
    logic [DUR_W-1:0] last_dur, max_dur;
    logic             wr_enable, wr_preset, chg_clr, active;

    assign wr_enable = wr_en && (wr_addr == REG_ENABLE);
    assign wr_preset = wr_en && (wr_addr == REG_PRESET);
    assign chg_clr   = wr_en && (wr_addr == REG_CHANGED) && (wr_data == '0);
    assign active    = q.armed && !q.cfg_fault;

    always_comb begin
        d = q;
        if (wr_enable) d.en_bits = wr_data;
        if (wr_en && (wr_addr == REG_DIR)) d.dir_bits = wr_data;
        if (wr_preset) d.preset = wr_data[PRE_W-1:0];
        if (arm) begin
            if (group_ok) begin
                d.armed = 1'b1;
            end else begin
                d.armed     = 1'b0;
                d.cfg_fault = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    eic_edge_sense #(.WIDTH(IN_W)) u_sense (
        .clk         (clk),
        .rst_n       (rst_n),
        .pins        (in_word),
        .enable_bits (q.en_bits),
        .dir_bits    (q.dir_bits),
        .hits        (hits)
    );

    eic_trigger #(.WIDTH(IN_W), .PRE_W(PRE_W)) u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .hits    (hits),
        .active  (active),
        .cnt_clr (wr_enable || wr_preset),
        .preset  (q.preset),
        .chg_clr (chg_clr),
        .ack     (hdl_start),
        .count   (count),
        .changed (changed),
        .overlap (overlap),
        .irq     (irq_w)
    );

    eic_dur_timer #(.DUR_W(DUR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (hdl_start),
        .done     (hdl_done),
        .tick     (tick_ms),
        .last_dur (last_dur),
        .max_dur  (max_dur)
    );

    assign irq = irq_w;

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            REG_ENABLE:  rd_data = q.en_bits;
            REG_DIR:     rd_data = q.dir_bits;
            REG_PRESET:  rd_data = IN_W'(q.preset);
            REG_COUNT:   rd_data = IN_W'(count);
            REG_CHANGED: rd_data = changed;
            REG_LAST:    rd_data = IN_W'(last_dur);
            REG_MAX:     rd_data = IN_W'(max_dur);
            default: begin
                rd_data[ST_OVERLAP]  = overlap;
                rd_data[ST_CFGFAULT] = q.cfg_fault;
                rd_data[ST_ARMED]    = q.armed;
                rd_data[ST_IRQ]      = irq_w;
            end
        endcase
    end

    // R10
    cfg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cfg_fault |=> q.cfg_fault);

    // R10
    no_irq_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !$rose(irq_w));

endmodule

// File: tb/tb_edge_irq_ctrl.sv
module tb_edge_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] in_word = '0;
    logic        group_ok = 1'b0;
    logic        arm = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        tick_ms = 1'b0;
    logic        hdl_start = 1'b0;
    logic        hdl_done = 1'b0;
    logic        irq;

    always #4 clk = ~clk;

    edge_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .in_word(in_word), .group_ok(group_ok),
        .arm(arm), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .tick_ms(tick_ms),
        .hdl_start(hdl_start), .hdl_done(hdl_done), .irq(irq)
    );

    typedef struct {
        int          sel;
        logic [15:0] exp;
        string       tag;
    } item_t;

    localparam int SEL_IRQ = 8;

    item_t q_exp[$];
    int n_cmp = 0;
    int n_bad = 0;
    int pushed = 0;
    int popped = 0;
    bit finished = 0;

    // Monitor: pops expected items and compares against the design
    initial begin
        forever begin
            @(negedge clk);
            if (q_exp.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it = q_exp.pop_front();
                if (it.sel != SEL_IRQ) rd_addr = it.sel[2:0];
                #1;
                act = (it.sel == SEL_IRQ) ? {15'd0, irq} : rd_data;
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
                end
                popped++;
            end
        end
    end

    task automatic expect_val(input int sel, input logic [15:0] exp, input string tag);
        item_t it;
        it.sel = sel; it.exp = exp; it.tag = tag;
        q_exp.push_back(it);
        pushed++;
        while (popped < pushed) @(posedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_in(input logic [15:0] v);
        @(negedge clk);
        in_word = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk); hdl_start = 1'b1;
        @(negedge clk); hdl_start = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); hdl_done = 1'b1;
        @(negedge clk); hdl_done = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_ms = 1'b1;
            @(negedge clk); tick_ms = 1'b0;
        end
    endtask

    task automatic do_arm(input logic ok);
        @(negedge clk); arm = 1'b1; group_ok = ok;
        @(negedge clk); arm = 1'b0;
    endtask

    // Input change lands so that the edge is judged in the same cycle as the extra action
    task automatic aligned(input logic [15:0] v, input bit zero_wr, input bit ack);
        @(negedge clk);
        in_word = v;
        @(negedge clk);
        @(negedge clk);
        if (zero_wr) begin wr_en = 1'b1; wr_addr = 3'd4; wr_data = '0; end
        if (ack) hdl_start = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; hdl_start = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R11 watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        expect_val(7, 16'h0000, "R11 status after reset");
        expect_val(SEL_IRQ, 16'h0000, "R11 irq after reset");
        expect_val(0, 16'h0000, "R11 enable after reset");
        expect_val(3, 16'h0000, "R11 count after reset");

        wr(3'd0, 16'h0003);
        wr(3'd1, 16'h0001);
        wr(3'd2, 16'h0000);
        set_in(16'h0001);
        expect_val(SEL_IRQ, 16'h0000, "R10 no irq before arm");
        expect_val(3, 16'h0000, "R10 no count before arm");

        do_arm(1'b1);
        expect_val(7, 16'h0004, "R10 armed status");

        set_in(16'h0000);
        expect_val(SEL_IRQ, 16'h0000, "R2 falling ignored on rising bit");
        set_in(16'h0001);
        expect_val(SEL_IRQ, 16'h0001, "R2 rising fires");
        expect_val(4, 16'h0001, "R5 changed bit0");
        expect_val(3, 16'h0000, "R3 count zero after fire");
        repeat (6) @(negedge clk);
        expect_val(SEL_IRQ, 16'h0001, "R7 irq held");

        pulse_start();
        expect_val(SEL_IRQ, 16'h0000, "R7 irq cleared by start");
        ticks(3);
        pulse_done();
        expect_val(5, 16'd3, "R8 last duration");
        expect_val(6, 16'd3, "R9 max duration");

        wr(3'd4, 16'h0000);
        expect_val(4, 16'h0000, "R5 zero write clears");

        set_in(16'h0003);
        expect_val(SEL_IRQ, 16'h0000, "R2 rising ignored on falling bit");
        set_in(16'h0001);
        expect_val(SEL_IRQ, 16'h0001, "R2 falling fires");
        expect_val(4, 16'h0002, "R5 changed bit1");
        wr(3'd4, 16'h0005);
        expect_val(4, 16'h0002, "R5 nonzero write ignored");

        pulse_start();
        set_in(16'h0005);
        expect_val(SEL_IRQ, 16'h0000, "R1 masked input no irq");
        expect_val(3, 16'h0000, "R1 masked input no count");
        set_in(16'h0001);
        set_in(16'h0000);

        aligned(16'h0001, 1'b1, 1'b0);
        expect_val(4, 16'h0001, "R6 zero write with fire");
        expect_val(7, 16'h000C, "R6 no overlap on same-cycle clear");

        set_in(16'h0003);
        aligned(16'h0001, 1'b0, 1'b1);
        expect_val(SEL_IRQ, 16'h0001, "R7 fire wins over start");
        expect_val(4, 16'h0003, "R5 changed merged");
        expect_val(7, 16'h000D, "R6 overlap flagged");

        ticks(1);
        pulse_done();
        expect_val(5, 16'd1, "R8 short run");
        expect_val(6, 16'd3, "R9 max kept");
        pulse_start();
        ticks(5);
        pulse_done();
        expect_val(SEL_IRQ, 16'h0000, "R7 cleared");
        expect_val(5, 16'd5, "R8 long run");
        expect_val(6, 16'd5, "R9 max raised");
        pulse_done();
        expect_val(5, 16'd5, "R8 stray done ignored");

        wr(3'd2, 16'd3);
        expect_val(2, 16'd3, "R12 preset readback");
        set_in(16'h0000);
        set_in(16'h0001);
        expect_val(3, 16'd1, "R3 count one");
        set_in(16'h0000);
        set_in(16'h0001);
        expect_val(3, 16'd2, "R3 count two");
        expect_val(SEL_IRQ, 16'h0000, "R3 below preset");
        wr(3'd0, 16'h0003);
        expect_val(3, 16'd0, "R4 enable write clears count");
        set_in(16'h0000);
        set_in(16'h0001);
        set_in(16'h0000);
        set_in(16'h0001);
        expect_val(SEL_IRQ, 16'h0000, "R3 two of three");
        set_in(16'h0000);
        set_in(16'h0001);
        expect_val(SEL_IRQ, 16'h0001, "R3 third event fires");
        expect_val(3, 16'd0, "R3 count reset");

        wr(3'd4, 16'h0000);
        pulse_start();
        wr(3'd1, 16'h0003);
        wr(3'd2, 16'd2);
        expect_val(1, 16'h0003, "R12 direction readback");
        set_in(16'h0000);
        set_in(16'h0003);
        expect_val(SEL_IRQ, 16'h0001, "R2 two events one cycle fire");
        expect_val(4, 16'h0003, "R5 both bits");
        expect_val(3, 16'd0, "R4 count cleared after fire");

        do_arm(1'b0);
        expect_val(7, 16'h000B, "R10 config fault");
        pulse_start();
        set_in(16'h0000);
        set_in(16'h0003);
        expect_val(SEL_IRQ, 16'h0000, "R10 no irq when faulted");
        expect_val(3, 16'd0, "R10 no count when faulted");

        do_reset();
        expect_val(7, 16'h0000, "R11 status cleared");
        expect_val(5, 16'h0000, "R11 last cleared");
        expect_val(6, 16'h0000, "R11 max cleared");
        expect_val(4, 16'h0000, "R11 changed cleared");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule